// File: doc/BRIEF.md
# Gated Configuration Register with Interrupt Pin Mode

This block is one configuration register of a network controller, together with the storage that it guards. Three control bits sit in the register. The LED-unlock bit opens four LED-function registers to bus writes. The shadow-unlock bit opens a 16-byte shadow RAM, which answers all station-address PROM accesses, to bus writes. The interrupt-mode bit sets how the interrupt pin is driven. While a gate is closed, bus writes to the storage behind it are dropped without effect.

Software reaches the register, the LED registers and the shadow bytes through one simple read/write port. Read data is registered. A load strobe restores the register's low half and all 16 shadow bytes from a serial-EEPROM image. The strobe ignores the gates. A hard reset clears the control bits. A soft reset or stop leaves all configuration state as it is.

Each LED pin shows the OR of the shared function inputs that its register enables. The interrupt pin comes out as a drive value and an output enable. A board-level pull-up or a bench can then resolve it.

Top module: `gcfg_top`

Address map used below: 0x00 is the control register, 0x04 to 0x07 are LED registers 0 to 3, and 0x20 to 0x2F are shadow bytes 0 to 15.

## Requirements
- R1: A hard reset (`rst_n` low at a clock edge) clears the control register to 0 and drops `rd_valid`. It sets every LED register to 0x8001: bit 0 enables function input 0 (link status) and bit 15 is the pulse-stretch flag.
- R2: A bus write to 0x00 stores only bit 12 (LED unlock), bit 8 (shadow unlock) and bit 7 (interrupt mode). Every other bit of the register reads back as 0.
- R3: A bus write to an LED register (0x04 + n, low 16 data bits) takes effect when bit 12 of the control register is 1. When bit 12 is 0, the write is ignored and the register keeps its old value.
- R4: A bus write to a shadow byte (0x20 + i, data bits 7:0) takes effect only when bit 8 of the control register is 1. A read of a shadow byte returns it in bits 7:0, with bits 31:8 at zero.
- R5: With bit 7 of the control register at 0, an active `irq_req` gives `irq_oe`=1 and `irq_drv`=0. An inactive `irq_req` gives `irq_oe`=0, which releases the pin.
- R6: With bit 7 of the control register at 1, `irq_oe` is always 1 and `irq_drv` equals `irq_req`.
- R7: A `soft_rst` pulse leaves the control register, the LED registers and the shadow bytes unchanged.
- R8: An `ee_load` pulse writes the control register from `ee_word` (same bit mask as R2) and loads shadow byte i from `ee_bytes[8*i+7:8*i]`, whatever the unlock bits are set to. If a bus write comes in the same cycle, the load wins and the bus write is dropped.
- R9: A read strobe returns data on `rd_data`, with `rd_valid` high, on the clock edge that follows the edge that samples the strobe. Unmapped addresses read as 0.
- R10: `led_o[n]` is the OR over k of (LED register n bit k AND `led_fn[k]`), for k below FN_W (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset / stop; clears the read-return path only |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| ee_load | input | 1 | EEPROM image load strobe |
| ee_word | input | 16 | Image for the control register's low half |
| ee_bytes | input | 128 | Image for the 16 shadow bytes, byte 0 in the low bits |
| led_fn | input | 8 | Shared LED function inputs |
| led_o | output | 4 | LED pin outputs |
| irq_req | input | 1 | Internal interrupt request |
| irq_drv | output | 1 | Interrupt pin drive value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The EEPROM load and a bus write can land in the same cycle. The bench provokes this twice. In the first case the bus writes the control register while the image carries different bits. In the second case the image unlocks the shadow RAM while the bus writes a shadow byte. In both cases the read-back must show the image's values, never the bus data.

// File: rtl/gcfg_pkg.sv
// Package: shared constants for the gated configuration register block.
// Assumes a 6-bit register address space and 16 shadow bytes.
package gcfg_pkg;
    localparam int CTRL_W      = 32;
    localparam int LED_W       = 16;
    localparam int BIT_LED_UNL = 12;
    localparam int BIT_SHD_UNL = 8;
    localparam int BIT_IRQ_MOD = 7;
    localparam logic [CTRL_W-1:0] CTRL_MASK =
        (32'd1 << BIT_LED_UNL) | (32'd1 << BIT_SHD_UNL) | (32'd1 << BIT_IRQ_MOD);
    localparam logic [LED_W-1:0] LED_RST = 16'h8001;
    localparam logic [5:0] ADDR_CTRL = 6'h00;
    localparam logic [3:0] ADDR_LED_HI = 4'b0001;  // addr[5:2] for LED registers
    localparam logic [1:0] ADDR_SHD_HI = 2'b10;    // addr[5:4] for shadow bytes
endpackage

// File: rtl/gcfg_ctrl.sv
// Module: control register. Holds the three control bits, masked.
// Assumes the EEPROM load has priority over the bus write.
module gcfg_ctrl
    import gcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              ee_load,
    input  logic [15:0]       ee_word,
    output logic [CTRL_W-1:0] ctrl_q
);
    // Purpose: hard-reset clear, load-over-write priority, mask reserved bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ee_load)
            ctrl_q <= {{(CTRL_W-16){1'b0}}, ee_word} & CTRL_MASK;
        else if (wr_en)
            ctrl_q <= wdata & CTRL_MASK;
    end

    AST_HRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_q == '0)); // R1
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0); // R2
    AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst && !wr_en && !ee_load) |=> $stable(ctrl_q)); // R7
endmodule

// File: rtl/gcfg_led_bank.sv
// Module: LED function registers with a write gate, plus OR-of-enabled outputs.
// Assumes all LEDs share one set of function inputs.
module gcfg_led_bank
    import gcfg_pkg::*;
#(
    parameter int N_LED = 4,
    parameter int FN_W  = 8,
    localparam int SEL_W = $clog2(N_LED)
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        unlock,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            sel,
    input  logic [LED_W-1:0]            wdata,
    input  logic [FN_W-1:0]             fn_in,
    output logic [N_LED-1:0][LED_W-1:0] regs_q,
    output logic [N_LED-1:0]            led_o
);
    for (genvar n = 0; n < N_LED; n++) begin : g_led
        // Purpose: gated write of one LED register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[n] <= LED_RST;
            else if (wr_en && unlock && sel == SEL_W'(n))
                regs_q[n] <= wdata;
        end
        // Purpose: LED shows any enabled function that is active.
        always_comb led_o[n] = |(regs_q[n][FN_W-1:0] & fn_in);
    end

    AST_LED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> $stable(regs_q)); // R3
endmodule

// File: rtl/gcfg_shadow.sv
// Module: 16-byte shadow RAM for address-PROM accesses.
// Assumes no reset of contents; the EEPROM load fills every byte at once.
module gcfg_shadow #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  unlock,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [7:0]            wdata,
    input  logic                  ee_load,
    input  logic [DEPTH*8-1:0]    ee_bytes,
    output logic [DEPTH-1:0][7:0] mem_q
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        // Purpose: load from image first, else gated bus write.
        always_ff @(posedge clk) begin
            if (ee_load)
                mem_q[i] <= ee_bytes[8*i +: 8];
            else if (wr_en && unlock && idx == IDX_W'(i))
                mem_q[i] <= wdata;
        end
    end

    AST_SHD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlock && !ee_load) |=> $stable(mem_q)); // R4
    AST_SHD_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        ee_load |=> (mem_q == $past(ee_bytes))); // R8
endmodule

// File: rtl/gcfg_irq_pin.sv
// Module: interrupt pin driver, shared open-drain or dedicated push-pull.
// Assumes an external pull-up when the enable is released.
module gcfg_irq_pin (
    input  logic clk,
    input  logic rst_n,
    input  logic push_pull,
    input  logic req,
    output logic drv,
    output logic oe
);
    // Purpose: choose drive value and enable from the mode bit.
    always_comb begin
        if (push_pull) begin
            drv = req;
            oe  = 1'b1;
        end else begin
            drv = 1'b0;
            oe  = req;
        end
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && oe) |-> !drv); // R5
    AST_PP_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> oe); // R6
endmodule

// File: rtl/gcfg_top.sv
// Module: top of the gated configuration block: decode, read path, wiring.
// Assumes single-cycle strobes; reads see the state before a same-cycle write.
module gcfg_top
    import gcfg_pkg::*;
#(
    parameter int FN_W = 8
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [5:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    input  logic          ee_load,
    input  logic [15:0]   ee_word,
    input  logic [127:0]  ee_bytes,
    input  logic [FN_W-1:0] led_fn,
    output logic [3:0]    led_o,
    input  logic          irq_req,
    output logic          irq_drv,
    output logic          irq_oe
);
    localparam int N_LED = 4;
    localparam int DEPTH = 16;

    logic [CTRL_W-1:0]            ctrl_q;
    logic [N_LED-1:0][LED_W-1:0]  led_regs;
    logic [DEPTH-1:0][7:0]        shd_mem;
    logic                         hit_ctrl, hit_led, hit_shd;
    logic [31:0]                  rd_mux;

    // Purpose: decode the address into the three targets.
    always_comb begin
        hit_ctrl = (bus_addr == ADDR_CTRL);
        hit_led  = (bus_addr[5:2] == ADDR_LED_HI);
        hit_shd  = (bus_addr[5:4] == ADDR_SHD_HI);
    end

    gcfg_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(bus_wr && hit_ctrl), .wdata(bus_wdata),
        .ee_load(ee_load), .ee_word(ee_word), .ctrl_q(ctrl_q)
    );

    gcfg_led_bank #(.N_LED(N_LED), .FN_W(FN_W)) i_led (
        .clk(clk), .rst_n(rst_n), .unlock(ctrl_q[BIT_LED_UNL]),
        .wr_en(bus_wr && hit_led && !ee_load), .sel(bus_addr[1:0]),
        .wdata(bus_wdata[LED_W-1:0]), .fn_in(led_fn),
        .regs_q(led_regs), .led_o(led_o)
    );

    gcfg_shadow #(.DEPTH(DEPTH)) i_shd (
        .clk(clk), .rst_n(rst_n), .unlock(ctrl_q[BIT_SHD_UNL]),
        .wr_en(bus_wr && hit_shd), .idx(bus_addr[3:0]),
        .wdata(bus_wdata[7:0]), .ee_load(ee_load), .ee_bytes(ee_bytes),
        .mem_q(shd_mem)
    );

    gcfg_irq_pin i_irq (
        .clk(clk), .rst_n(rst_n), .push_pull(ctrl_q[BIT_IRQ_MOD]),
        .req(irq_req), .drv(irq_drv), .oe(irq_oe)
    );

    // Purpose: select read data for the addressed target.
    always_comb begin
        rd_mux = '0;
        if (hit_ctrl)     rd_mux = ctrl_q;
        else if (hit_led) rd_mux = {16'h0, led_regs[bus_addr[1:0]]};
        else if (hit_shd) rd_mux = {24'h0, shd_mem[bus_addr[3:0]]};
    end

    // Purpose: register the read return; soft reset only clears this path.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= bus_rd;
            rd_data  <= bus_rd ? rd_mux : '0;
        end
    end

    AST_RD_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        bus_rd |=> rd_valid); // R9
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid); // R9
endmodule

// File: tb/test_gcfg_top.sv
module test_gcfg_top;
    logic         clk = 0;
    logic         rst_n = 0, soft_rst = 0;
    logic         bus_wr = 0, bus_rd = 0;
    logic [5:0]   bus_addr = 0;
    logic [31:0]  bus_wdata = 0;
    logic [31:0]  rd_data;
    logic         rd_valid;
    logic         ee_load = 0;
    logic [15:0]  ee_word = 0;
    logic [127:0] ee_bytes = 0;
    logic [7:0]   led_fn = 0;
    logic [3:0]   led_o;
    logic         irq_req = 0;
    logic         irq_drv, irq_oe;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    gcfg_top i_gcfg_top (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0;
        chk(rd_valid === 1'b1, "R9", {31'b0, rd_valid}, 32'h1);
        chk(rd_data === exp, req, rd_data, exp);
    endtask

    // {is_read, addr, wdata, expected}
    localparam int NV = 16;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 6'h00, 32'h0,        32'h0},        // R1 ctrl after reset
        {1'b1, 6'h05, 32'h0,        32'h8001},     // R1 LED default
        {1'b0, 6'h04, 32'h00FF,     32'h0},        // R3 locked write
        {1'b1, 6'h04, 32'h0,        32'h8001},     // R3 ignored
        {1'b0, 6'h00, 32'hFFFFFFFF, 32'h0},        // R2 all ones
        {1'b1, 6'h00, 32'h0,        32'h1180},     // R2 mask
        {1'b0, 6'h05, 32'h0003,     32'h0},        // R3 unlocked
        {1'b1, 6'h05, 32'h0,        32'h0003},     // R3 took effect
        {1'b0, 6'h25, 32'hFFAB,     32'h0},        // R4 unlocked
        {1'b1, 6'h25, 32'h0,        32'h00AB},     // R4 byte in 7:0
        {1'b0, 6'h00, 32'h1000,     32'h0},        // R4 relock shadow
        {1'b0, 6'h25, 32'h11,       32'h0},        // R4 locked write
        {1'b1, 6'h25, 32'h0,        32'h00AB},     // R4 ignored
        {1'b1, 6'h3A, 32'h0,        32'h0},        // R9 unmapped
        {1'b0, 6'h00, 32'h0,        32'h0},        // R3 relock LEDs
        {1'b0, 6'h05, 32'h0007,     32'h0}         // R3 locked again
    };

    initial begin
        #(4*200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rd_valid === 1'b0, "R1", {31'b0, rd_valid}, 32'h0);
        chk(irq_oe === 1'b0, "R5", {31'b0, irq_oe}, 32'h0);
        led_fn = 8'h01; #1;
        chk(led_o === 4'hF, "R10", {28'b0, led_o}, 32'hF);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][70]) rd_chk(VEC[k][69:64], VEC[k][31:0], "table");
            else            wr(VEC[k][69:64], VEC[k][63:32]);
        end
        rd_chk(6'h05, 32'h0003, "R3 locked LED kept");

        // R10: OR of enabled functions
        led_fn = 8'h02; #1;
        chk(led_o === 4'b0010, "R10", {28'b0, led_o}, 32'h2);
        led_fn = 8'h81; #1;
        chk(led_o === 4'b1111, "R10", {28'b0, led_o}, 32'hF);
        led_fn = 8'h00; #1;
        chk(led_o === 4'b0000, "R10", {28'b0, led_o}, 32'h0);

        // R5: open-drain mode (ctrl is 0)
        irq_req = 1; #1;
        chk(irq_oe === 1 && irq_drv === 0, "R5", {30'b0, irq_oe, irq_drv}, 32'h2);
        irq_req = 0; #1;
        chk((irq_oe ? irq_drv : 1'b1) === 1'b1, "R5 pulled up", {30'b0, irq_oe, irq_drv}, 32'h0);
        // R6: push-pull mode
        wr(6'h00, 32'h80);
        irq_req = 1; #1;
        chk(irq_oe === 1 && irq_drv === 1, "R6", {30'b0, irq_oe, irq_drv}, 32'h3);
        irq_req = 0; #1;
        chk(irq_oe === 1 && irq_drv === 0, "R6", {30'b0, irq_oe, irq_drv}, 32'h2);

        // R7: soft reset keeps state
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        rd_chk(6'h00, 32'h80, "R7 ctrl");
        rd_chk(6'h05, 32'h3, "R7 LED");
        rd_chk(6'h25, 32'hAB, "R7 shadow");

        // R8: load and bus write to ctrl in the same cycle
        for (int i = 0; i < 16; i++) ee_bytes[8*i +: 8] = 8'h30 + 8'(i);
        @(negedge clk); ee_load = 1; ee_word = 16'hFFFF;
        bus_wr = 1; bus_addr = 6'h00; bus_wdata = 32'h0;
        @(negedge clk); ee_load = 0; bus_wr = 0;
        rd_chk(6'h00, 32'h1180, "R8 load wins ctrl");
        rd_chk(6'h2F, 32'h3F, "R8 shadow byte 15");
        // R8: load wins over a shadow write
        @(negedge clk); ee_load = 1; ee_word = 16'h1100;
        bus_wr = 1; bus_addr = 6'h20; bus_wdata = 32'h99;
        @(negedge clk); ee_load = 0; bus_wr = 0;
        rd_chk(6'h20, 32'h30, "R8 load wins shadow");
        rd_chk(6'h00, 32'h1100, "R8 ctrl image");

        // R1: hard reset mid-run
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd_chk(6'h00, 32'h0, "R1 ctrl cleared");
        rd_chk(6'h05, 32'h8001, "R1 LED default");
        @(negedge clk);
        chk(rd_valid === 1'b0, "R9 idle", {31'b0, rd_valid}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule